// File: doc/BRIEF.md
# Main Link Pattern State Controller

This block decides what a link transmitter places on its lanes. A host writes a one-hot selection word. The word picks one of four training patterns, a symbol-error-rate measurement pattern, a PRBS7 stream, a host-defined 80-bit pattern, video, or the idle pattern. The selection goes out on `mode_q`, and the encoder and packer downstream act on it. The block makes the PRBS7 and custom-pattern symbols itself and drives them on every lane in parallel. For all other selections it drives zero symbols.

The block enforces the selection rules itself. A new pattern can be selected only from the cleared state. The one exception is idle, which may be entered from any state. Once idle has been entered, no training pattern is taken until a soft reset. Two sticky, write-one-to-clear interrupt bits report progress:
- one bit is raised when video has been selected for a full transfer-unit period;
- one bit is raised when idle has been held for its required dwell.

Top module: `lnk_pattern_ctrl`

## Requirements
- R1: After `rst_n` is low, `mode_q` is 0, `irq_q` is 0, `sel_err_q` is 0 and every lane symbol is 0.
- R2: A state write puts address 0 on `wr_sel`, and only `wr_data[8:0]` is decoded. The bit meanings are: bits 0..3 are training patterns 1..4, bit 4 is error-rate measurement, bit 5 is PRBS7, bit 6 is the custom pattern, bit 7 is video and bit 8 is idle. A single-bit write made while `mode_q` is 0 appears on `mode_q` one cycle after the write edge.
- R3: A state write with two or more of bits 8..0 set leaves `mode_q` unchanged and sets `sel_err_q`.
- R4: Writing 0 always clears `mode_q`. A nonzero write other than idle, made while `mode_q` is nonzero, is ignored and sets `sel_err_q`.
- R5: In the PRBS7 state each lane carries SYM_W bits per cycle from the generator x^7+x^6+1. Each generated bit is s[6]^s[5] and is shifted into s[0]. Symbol bit 0 is the earliest bit. The generator is seeded to 7'h7F on entry, so the first symbol appears in the cycle after the write.
- R6: The 80-bit custom pattern is made of three host registers. Address 1 holds bits 31:0, address 2 holds bits 63:32, and address 3 holds bits 79:64 in its low 16 bits. Symbol k is pattern bits [10k+9:10k]. Output starts at k=0 on entry and k advances by one each cycle, wrapping after k=7.
- R7: `irq_q[0]` (ready for video) is set TU_LEN cycles after video is selected, provided video stays selected for that long.
- R8: Idle may be selected from any state. `irq_q[3]` (idle sent) is set IDLE_LEN cycles after idle is selected.
- R9: After idle has been entered, a write that selects a training pattern (bits 0..3) is ignored and sets `sel_err_q` until `soft_rst` is asserted. `soft_rst` clears `mode_q`, `irq_q`, `sel_err_q` and this lock.
- R10: Writing to address 4 clears each `irq_q` bit whose matching `wr_data` bit is 1. Other bits are unchanged.
- R11: In every state except PRBS7 and custom, all lane symbols are 0. All lanes always carry the same symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous soft reset of state, interrupts, error and idle lock |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Write address: 0 state, 1..3 pattern words, 4 interrupt clear |
| wr_data | input | DATA_W | Host write data |
| mode_q | output | 9 | Current one-hot selection |
| irq_q | output | 4 | Sticky interrupts: bit 0 video ready, bit 3 idle sent |
| sel_err_q | output | 1 | Sticky flag for a rejected state write |
| lane_sym | output | LANES*SYM_W | Per-lane symbol, lane 0 in the low bits |

## Verification
The bench builds the block with LANES=2, TU_LEN=6 and IDLE_LEN=9. With two lanes, the lane-equality rule is checked on every symbol. The short dwell values let both interrupt timers be checked at their exact edge, one cycle before and at the firing cycle, within a few cycles each. SYM_W=10 with eight symbols keeps the full 80-bit rotation and its wrap in reach. Random pattern words are then checked against a bench-side rotation model.

// File: rtl/lp_pkg.sv
package lp_pkg;
   localparam int ST_BITS   = 9;
   localparam int ST_TRAIN0 = 0;
   localparam int ST_TRAINN = 4;
   localparam int ST_SER    = 4;
   localparam int ST_PRBS   = 5;
   localparam int ST_CUST   = 6;
   localparam int ST_VIDEO  = 7;
   localparam int ST_IDLE   = 8;
   localparam int IRQ_W     = 4;
   localparam int IRQ_VIDEO = 0;
   localparam int IRQ_IDLE  = 3;
   localparam int SEL_W     = 3;
   localparam logic [SEL_W-1:0] SEL_STATE = 3'd0;
   localparam logic [SEL_W-1:0] SEL_PAT0  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_PAT1  = 3'd2;
   localparam logic [SEL_W-1:0] SEL_PAT2  = 3'd3;
   localparam logic [SEL_W-1:0] SEL_ICLR  = 3'd4;
endpackage

// File: rtl/lp_prbs7.sv
module lp_prbs7 #(
   parameter int SYM_W = 10,
   parameter logic [6:0] SEED = 7'h7F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             run,
   output logic [SYM_W-1:0] sym
);
   logic [6:0] lfsr_q;
   logic [6:0] lfsr_nxt;

   generate
      if (SEED == 7'd0) begin : g_bad_seed
         $error("lp_prbs7: seed must be nonzero");
      end
   endgenerate

   always_comb begin
      logic [6:0] s;
      logic       b;
      s = lfsr_q;
      sym = '0;
      for (int i = 0; i < SYM_W; i++) begin
         b = s[6] ^ s[5];
         sym[i] = b;
         s = {s[5:0], b};
      end
      lfsr_nxt = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    lfsr_q <= SEED;
      else if (load) lfsr_q <= SEED;
      else if (run)  lfsr_q <= lfsr_nxt;
   end

   // R5: the generator can never fall into the all-zero lock-up state
   p_lfsr_live_r5: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_q != 7'd0);
   // R5: entry always restarts from the seed
   p_seed_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> lfsr_q == SEED);
endmodule

// File: rtl/lp_pat_rot.sv
module lp_pat_rot #(
   parameter int SYM_W = 10,
   parameter int NSYM  = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  load,
   input  logic                  run,
   input  logic [SYM_W*NSYM-1:0] pattern,
   output logic [SYM_W-1:0]      sym
);
   localparam int IDX_W = (NSYM > 1) ? $clog2(NSYM) : 1;
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NSYM - 1);

   logic [IDX_W-1:0] idx_q;

   generate
      if (NSYM < 2) begin : g_bad_nsym
         $error("lp_pat_rot: NSYM must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                idx_q <= '0;
      else if (load)             idx_q <= '0;
      else if (run) idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
   end

   assign sym = pattern[idx_q*SYM_W +: SYM_W];

   // R6: index stays inside the pattern
   p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST);
   // R6: rotation wraps back to the first symbol
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !load && idx_q == LAST) |=> idx_q == '0);
endmodule

// File: rtl/lp_dwell.sv
module lp_dwell #(
   parameter int LEN = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   input  logic run,
   output logic fire
);
   localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
   localparam logic [CW-1:0] END = CW'(LEN - 1);

   logic [CW-1:0] cnt_q;
   logic          armed_q;

   generate
      if (LEN < 2) begin : g_bad_len
         $error("lp_dwell: LEN must be at least 2");
      end
   endgenerate

   assign fire = armed_q && run && !start && !clr && (cnt_q == END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (clr) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (start) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (!run || fire) begin
         armed_q <= 1'b0;
      end else if (armed_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R7/R8: counter never runs past its terminal value while armed
   p_cnt_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> cnt_q <= END);
   // R7/R8: one firing per arming
   p_single_fire_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !armed_q);
endmodule

// File: rtl/lnk_pattern_ctrl.sv
module lnk_pattern_ctrl
   import lp_pkg::*;
#(
   parameter int LANES    = 4,
   parameter int DATA_W   = 32,
   parameter int SYM_W    = 10,
   parameter int NSYM     = 8,
   parameter int TU_LEN   = 64,
   parameter int IDLE_LEN = 256
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   soft_rst,
   input  logic                   wr_en,
   input  logic [2:0]             wr_sel,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [8:0]             mode_q,
   output logic [3:0]             irq_q,
   output logic                   sel_err_q,
   output logic [LANES*SYM_W-1:0] lane_sym
);
   localparam int PAT_W  = SYM_W * NSYM;
   localparam int NWORDS = 3;
   localparam int FLAT_W = NWORDS * DATA_W;

   generate
      if (FLAT_W < PAT_W) begin : g_bad_pat
         $error("lnk_pattern_ctrl: pattern words too narrow");
      end
      if (DATA_W < ST_BITS) begin : g_bad_dw
         $error("lnk_pattern_ctrl: DATA_W below state width");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("lnk_pattern_ctrl: LANES must be positive");
      end
   endgenerate

   logic [NWORDS-1:0][DATA_W-1:0] pat_q;
   logic [FLAT_W-1:0]             pat_flat;
   logic [ST_BITS-1:0]            wd;
   logic                          st_wr, multi, is_train, accept, idle_lock_q;
   logic [ST_BITS-1:0]            enter;
   logic                          vid_fire, idle_fire;
   logic [SYM_W-1:0]              prbs_sym, cust_sym, cur_sym;
   logic [IRQ_W-1:0]              irq_set, irq_clr;

   assign wd       = wr_data[ST_BITS-1:0];
   assign st_wr    = wr_en && (wr_sel == SEL_STATE) && !soft_rst;
   assign multi    = $countones(wd) > 1;
   assign is_train = |wd[ST_TRAINN-1:ST_TRAIN0];
   assign accept   = st_wr && !multi && !(idle_lock_q && is_train)
                     && (wd == '0 || wd[ST_IDLE] || mode_q == '0);
   assign enter    = accept ? wd : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= '0;
         sel_err_q   <= 1'b0;
         idle_lock_q <= 1'b0;
      end else if (soft_rst) begin
         mode_q      <= '0;
         sel_err_q   <= 1'b0;
         idle_lock_q <= 1'b0;
      end else begin
         if (accept) mode_q <= wd;
         if (st_wr && !accept) sel_err_q <= 1'b1;
         if (enter[ST_IDLE]) idle_lock_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pat_q <= '0;
      else if (wr_en) begin
         case (wr_sel)
            SEL_PAT0: pat_q[0] <= wr_data;
            SEL_PAT1: pat_q[1] <= wr_data;
            SEL_PAT2: pat_q[2] <= wr_data;
            default: ;
         endcase
      end
   end
   assign pat_flat = pat_q;

   lp_dwell #(.LEN(TU_LEN)) u_vid_dwell (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .start(enter[ST_VIDEO]), .run(mode_q[ST_VIDEO]), .fire(vid_fire));

   lp_dwell #(.LEN(IDLE_LEN)) u_idle_dwell (
      .clk(clk), .rst_n(rst_n), .clr(soft_rst),
      .start(enter[ST_IDLE]), .run(mode_q[ST_IDLE]), .fire(idle_fire));

   always_comb begin
      irq_set = '0;
      irq_set[IRQ_VIDEO] = vid_fire;
      irq_set[IRQ_IDLE]  = idle_fire;
      irq_clr = (wr_en && wr_sel == SEL_ICLR) ? wr_data[IRQ_W-1:0] : '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        irq_q <= '0;
      else if (soft_rst) irq_q <= '0;
      else               irq_q <= (irq_q & ~irq_clr) | irq_set;
   end

   lp_prbs7 #(.SYM_W(SYM_W), .SEED(7'h7F)) u_prbs (
      .clk(clk), .rst_n(rst_n), .load(enter[ST_PRBS]),
      .run(mode_q[ST_PRBS]), .sym(prbs_sym));

   lp_pat_rot #(.SYM_W(SYM_W), .NSYM(NSYM)) u_rot (
      .clk(clk), .rst_n(rst_n), .load(enter[ST_CUST]),
      .run(mode_q[ST_CUST]), .pattern(pat_flat[PAT_W-1:0]), .sym(cust_sym));

   always_comb begin
      if (mode_q[ST_PRBS])      cur_sym = prbs_sym;
      else if (mode_q[ST_CUST]) cur_sym = cust_sym;
      else                      cur_sym = '0;
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign lane_sym[l*SYM_W +: SYM_W] = cur_sym;
   end

   // R2: selection is always one-hot or cleared
   p_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_q));
   // R3: multi-bit selection leaves the state untouched
   p_multi_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == SEL_STATE && !soft_rst && $countones(wd) > 1)
      |=> $stable(mode_q) && sel_err_q);
   // R9: after idle, no training pattern until soft reset
   p_idle_lock_r9: assert property (@(posedge clk) disable iff (!rst_n)
      idle_lock_q |-> mode_q[ST_TRAINN-1:ST_TRAIN0] == '0);
   // R8: idle-sent only follows a held idle state
   p_idle_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q[IRQ_IDLE]) |-> $past(mode_q[ST_IDLE]));
   // R7: ready-for-video only follows a held video state
   p_video_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_q[IRQ_VIDEO]) |-> $past(mode_q[ST_VIDEO]));
   // R11: no symbols outside the generated-pattern states
   p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_q[ST_PRBS] || mode_q[ST_CUST]) |-> lane_sym == '0);
endmodule

// File: tb/lnk_pattern_ctrl_test.sv
module lnk_pattern_ctrl_test;
   localparam int LANES = 2, DATA_W = 32, SYM_W = 10, NSYM = 8;
   localparam int TU_LEN = 6, IDLE_LEN = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
   logic [2:0] wr_sel = '0;
   logic [DATA_W-1:0] wr_data = '0;
   logic [8:0] mode_q;
   logic [3:0] irq_q;
   logic sel_err_q;
   logic [LANES*SYM_W-1:0] lane_sym;

   int total = 0, bad = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   lnk_pattern_ctrl #(.LANES(LANES), .DATA_W(DATA_W), .SYM_W(SYM_W),
      .NSYM(NSYM), .TU_LEN(TU_LEN), .IDLE_LEN(IDLE_LEN)) uut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .mode_q(mode_q), .irq_q(irq_q),
      .sel_err_q(sel_err_q), .lane_sym(lane_sym));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [DATA_W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse_soft();
      @(negedge clk);
      soft_rst = 1'b1;
      @(negedge clk);
      soft_rst = 1'b0;
   endtask

   function automatic logic [16:0] prbs_ref(input logic [6:0] s);
      logic [9:0] sym;
      logic b;
      for (int i = 0; i < SYM_W; i++) begin
         b = s[6] ^ s[5];
         sym[i] = b;
         s = {s[5:0], b};
      end
      return {s, sym};
   endfunction

   task automatic lanes_chk(input string req, input logic [SYM_W-1:0] exp);
      chk(req, lane_sym[SYM_W-1:0], exp);
      chk("R11 lanes equal", lane_sym[2*SYM_W-1:SYM_W], lane_sym[SYM_W-1:0]);
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin : main
      logic [6:0] s;
      logic [16:0] r;
      logic [79:0] pat;
      logic [31:0] w0, w1, w2;
      void'($urandom(32'd2024));

      repeat (3) @(negedge clk);
      chk("R1 mode", mode_q, 0);
      chk("R1 irq", irq_q, 0);
      chk("R1 err", sel_err_q, 0);
      chk("R1 syms", lane_sym, 0);
      rst_n = 1'b1;

      // R2 + R5: PRBS from cleared state
      wr(3'd0, 32'h20);
      chk("R2 prbs selected", mode_q, 9'h020);
      s = 7'h7F;
      for (int k = 0; k < 12; k++) begin
         r = prbs_ref(s);
         lanes_chk("R5 prbs symbol", r[9:0]);
         s = r[16:10];
         @(negedge clk);
      end
      wr(3'd0, 32'h0);
      chk("R4 clear", mode_q, 0);
      lanes_chk("R11 quiet after clear", '0);

      // R3
      wr(3'd0, 32'h003);
      chk("R3 multi ignored", mode_q, 0);
      chk("R3 err set", sel_err_q, 1);
      pulse_soft();
      chk("R9 soft clears err", sel_err_q, 0);

      // R4
      wr(3'd0, 32'h001);
      chk("R2 tp1", mode_q, 9'h001);
      lanes_chk("R11 quiet in training", '0);
      wr(3'd0, 32'h002);
      chk("R4 switch ignored", mode_q, 9'h001);
      chk("R4 err", sel_err_q, 1);
      wr(3'd0, 32'h0);
      wr(3'd0, 32'h002);
      chk("R4 after clear", mode_q, 9'h002);
      wr(3'd0, 32'h0);
      pulse_soft();

      // R7 + R10
      wr(3'd0, 32'h080);
      repeat (TU_LEN - 1) @(negedge clk);
      chk("R7 not yet", irq_q[0], 0);
      @(negedge clk);
      chk("R7 video ready", irq_q, 4'h1);
      wr(3'd4, 32'h8);
      chk("R10 other bit kept", irq_q, 4'h1);
      wr(3'd4, 32'h1);
      chk("R10 cleared", irq_q, 4'h0);
      repeat (TU_LEN + 2) @(negedge clk);
      chk("R10 stays clear", irq_q, 4'h0);

      // R8: idle from video
      wr(3'd0, 32'h100);
      chk("R8 idle from video", mode_q, 9'h100);
      repeat (IDLE_LEN - 1) @(negedge clk);
      chk("R8 not yet", irq_q[3], 0);
      @(negedge clk);
      chk("R8 idle sent", irq_q, 4'h8);

      // R9
      wr(3'd0, 32'h0);
      wr(3'd0, 32'h001);
      chk("R9 training locked", mode_q, 0);
      chk("R9 err", sel_err_q, 1);
      wr(3'd0, 32'h020);
      chk("R9 non-training allowed", mode_q, 9'h020);
      wr(3'd0, 32'h0);
      pulse_soft();
      chk("R9 soft mode", mode_q, 0);
      chk("R9 soft irq", irq_q, 0);
      chk("R9 soft err", sel_err_q, 0);
      wr(3'd0, 32'h001);
      chk("R9 training after soft", mode_q, 9'h001);
      wr(3'd0, 32'h0);

      // R6 random custom patterns
      for (int it = 0; it < 6; it++) begin
         w0 = $urandom; w1 = $urandom; w2 = $urandom;
         if (it == 0) begin w0 = 32'h0; w1 = 32'hFFFF_FFFF; w2 = 32'hA5A5; end
         wr(3'd1, w0); wr(3'd2, w1); wr(3'd3, w2);
         pat = {w2[15:0], w1, w0};
         wr(3'd0, 32'h040);
         for (int k = 0; k < 11; k++) begin
            lanes_chk("R6 custom symbol", pat[(k % NSYM)*SYM_W +: SYM_W]);
            @(negedge clk);
         end
         wr(3'd0, 32'h0);
      end

      // R2 random single-bit selections, upper data bits ignored
      for (int it = 0; it < 12; it++) begin
         int b;
         b = int'($urandom % 8);
         wr(3'd0, (32'h1 << b) | 32'hFFFF_FE00);
         chk("R2 random select", mode_q, 9'h1 << b);
         wr(3'd0, 32'h0);
      end

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule